// File: doc/BRIEF.md
# Serial Successive-Approximation Output Sequencer

This block is the digital heart of a 12-bit successive-approximation converter that talks over a three-wire serial port. A host pulls the active-low select line down and then toggles the data clock. The sequencer spends the first clock periods sampling. It then enables the serial output, drives a low lead-in bit, and runs one binary-search trial per clock against an external comparator. Each decided bit appears on the serial line in the same clock period in which it is decided, so there is no pipeline delay.

Once the last bit is out, the analog section is flagged for power-down while the clock keeps running. By default, further clocks replay the word least significant bit first, and the line then floats. A build option instead holds the line low for as long as clocks continue. Raising the select line at any time ends the cycle at once: the output floats and both sections power down. A host can therefore cut a conversion short after only the bits it needs. There is no data stream with back-pressure here. The serial line is paced entirely by the host clock, so every pin is a plain control or data pin.

Top module: `sar_serial_seq`

## Requirements
- R1: While `cs_n` is high, `dout_oe` is 0 and `analog_pd` and `digital_pd` are both 1. Raising `cs_n` during any phase aborts the cycle at once.
- R2: After `cs_n` falls, `dout_oe` stays 0 through the first falling `dclk` edge. The second falling edge sets `dout_oe` to 1 and `dout` to 0 (the lead-in bit) for one period.
- R3: Falling edges 3 to 14 after `cs_n` falls drive result bits 11 down to 0 in turn (MSB first). Each bit is driven at the edge on which it is decided.
- R4: Bit trials set the trial bit on `dac_code` to 1. The bit is kept if `cmp_hi` is 1 (input at or above `dac_code`) and cleared otherwise. Between falling edges k and k+1 (k = 2..13), `dac_code` holds the decided upper bits, a 1 at bit 13-k, and zeros below it.
- R5: The result is straight binary. An input code of 000h, 7FFh, 800h or FFFh yields that same code on `dout`.
- R6: With `cs_n` low, `digital_pd` is 0. `analog_pd` is 0 until the 14th falling edge, becomes 1 at that edge, and stays 1.
- R7: With `ZERO_TAIL`=0, edges 15 to 25 drive result bits 1 to 11 in turn (LSB first). From edge 26 on, `dout_oe` is 0 for every further clock while `cs_n` stays low.
- R8: With `ZERO_TAIL`=1, from edge 15 on, `dout_oe` stays 1 and `dout` stays 0 for every further clock.
- R9: A new conversion starts only on a fall of `cs_n`. After an abort at any point, the next cycle runs the full sequence from the sample window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dclk | input | 1 | Host data clock; state advances on its falling edge |
| cs_n | input | 1 | Active-low select; high aborts and shuts down |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above `dac_code` |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Serial output enable (0 models high impedance) |
| dac_code | output | NBITS | Capacitor-array trial code |
| analog_pd | output | 1 | Analog bias and comparator power-down |
| digital_pd | output | 1 | Digital section power-down |

## Verification
Every output is registered on the falling `dclk` edge. The result of falling edge k, counted from the fall of `cs_n`, is therefore due half a period later and holds until edge k+1. The bench lowers and raises `cs_n` just after a rising edge. It counts falling edges and samples all outputs on the next rising edge, comparing them with the value its model predicts for that edge number. Aborts act asynchronously, so they are checked one time step after `cs_n` rises, before any further clock edge.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_SAMPLE,
    PH_LEAD,
    PH_CONV,
    PH_TAIL,
    PH_QUIET
  } phase_t;
endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic                       dclk,
  input  logic                       cs_n,
  output phase_t                     phase_nx,
  output logic [$clog2(NBITS)-1:0]   idx_nx
);
  localparam int LEAD_EDGE  = 2;
  localparam int LAST_CONV  = NBITS + 2;
  localparam int LAST_TAIL  = 2 * NBITS + 1;
  localparam int QUIET_EDGE = 2 * NBITS + 2;
  localparam int CW         = $clog2(QUIET_EDGE + 1);
  localparam int IW         = $clog2(NBITS);

  logic [CW-1:0] edges_q;
  logic [CW-1:0] edges_nx;

  // edges_q counts falling edges since select fell, saturating.
  always_comb begin
    if (edges_q == CW'(QUIET_EDGE)) edges_nx = edges_q;
    else                            edges_nx = edges_q + CW'(1);
  end

  always_ff @(negedge dclk or posedge cs_n) begin
    if (cs_n) edges_q <= '0;
    else      edges_q <= edges_nx;
  end

  always_comb begin
    idx_nx = '0;
    if (edges_nx < CW'(LEAD_EDGE)) begin
      phase_nx = PH_SAMPLE;
    end else if (edges_nx == CW'(LEAD_EDGE)) begin
      phase_nx = PH_LEAD;
    end else if (edges_nx <= CW'(LAST_CONV)) begin
      phase_nx = PH_CONV;
      idx_nx   = IW'(CW'(LAST_CONV) - edges_nx);
    end else if (edges_nx <= CW'(LAST_TAIL)) begin
      phase_nx = PH_TAIL;
      idx_nx   = IW'(edges_nx - CW'(LAST_CONV));
    end else begin
      phase_nx = PH_QUIET;
    end
  end
endmodule

// File: rtl/sar_seq_reg.sv
module sar_seq_reg
  import sar_seq_pkg::*;
#(
  parameter int NBITS = 12
) (
  input  logic             dclk,
  input  logic             cs_n,
  input  phase_t           phase_nx,
  input  logic             cmp_hi,
  output logic [NBITS-1:0] result,
  output logic [NBITS-1:0] dac_code,
  output logic             decided
);
  localparam logic [NBITS-1:0] TOP_TRIAL = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] trial_q;
  logic [NBITS-1:0] result_q;
  logic             decided_q;

  always_ff @(negedge dclk or posedge cs_n) begin
    if (cs_n) begin
      trial_q   <= '0;
      result_q  <= '0;
      decided_q <= 1'b0;
    end else if (phase_nx == PH_LEAD) begin
      trial_q  <= TOP_TRIAL;
      result_q <= '0;
    end else if (phase_nx == PH_CONV) begin
      if (cmp_hi) result_q <= result_q | trial_q;
      trial_q <= trial_q >> 1;
      if (trial_q[0]) decided_q <= 1'b1;
    end
  end

  assign result   = result_q;
  assign dac_code = result_q | trial_q;
  assign decided  = decided_q;
endmodule

// File: rtl/sar_seq_out.sv
module sar_seq_out
  import sar_seq_pkg::*;
#(
  parameter int NBITS     = 12,
  parameter bit ZERO_TAIL = 1'b0
) (
  input  logic                     dclk,
  input  logic                     cs_n,
  input  phase_t                   phase_nx,
  input  logic [$clog2(NBITS)-1:0] idx_nx,
  input  logic                     cmp_hi,
  input  logic [NBITS-1:0]         result,
  output logic                     dout,
  output logic                     dout_oe
);
  logic d_nx, oe_nx;
  logic tail_bit;

  generate
    if (ZERO_TAIL) begin : g_zero
      assign tail_bit = 1'b0;
    end else begin : g_replay
      assign tail_bit = result[idx_nx];
    end
  endgenerate

  always_comb begin
    d_nx  = 1'b0;
    oe_nx = 1'b0;
    case (phase_nx)
      PH_LEAD:  oe_nx = 1'b1;
      PH_CONV:  begin oe_nx = 1'b1; d_nx = cmp_hi; end
      PH_TAIL:  begin oe_nx = 1'b1; d_nx = tail_bit; end
      PH_QUIET: oe_nx = ZERO_TAIL;
      default:  oe_nx = 1'b0;
    endcase
  end

  always_ff @(negedge dclk or posedge cs_n) begin
    if (cs_n) begin
      dout    <= 1'b0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= d_nx;
      dout_oe <= oe_nx;
    end
  end
endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int NBITS     = 12,
  parameter bit ZERO_TAIL = 1'b0
) (
  input  logic             dclk,
  input  logic             cs_n,
  input  logic             cmp_hi,
  output logic             dout,
  output logic             dout_oe,
  output logic [NBITS-1:0] dac_code,
  output logic             analog_pd,
  output logic             digital_pd
);
  localparam int IW = $clog2(NBITS);

  phase_t           phase_nx;
  logic [IW-1:0]    idx_nx;
  logic [NBITS-1:0] result;
  logic             decided;

  sar_seq_timer #(.NBITS(NBITS)) u_timer (
    .dclk(dclk), .cs_n(cs_n), .phase_nx(phase_nx), .idx_nx(idx_nx)
  );

  sar_seq_reg #(.NBITS(NBITS)) u_sar (
    .dclk(dclk), .cs_n(cs_n), .phase_nx(phase_nx), .cmp_hi(cmp_hi),
    .result(result), .dac_code(dac_code), .decided(decided)
  );

  sar_seq_out #(.NBITS(NBITS), .ZERO_TAIL(ZERO_TAIL)) u_out (
    .dclk(dclk), .cs_n(cs_n), .phase_nx(phase_nx), .idx_nx(idx_nx),
    .cmp_hi(cmp_hi), .result(result), .dout(dout), .dout_oe(dout_oe)
  );

  assign analog_pd  = cs_n | decided;
  assign digital_pd = cs_n;
endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
  parameter int NBITS     = 12,
  parameter bit ZERO_TAIL = 1'b0
) (
  input logic             dclk,
  input logic             cs_n,
  input logic             dout,
  input logic             dout_oe,
  input logic [NBITS-1:0] dac_code,
  input logic             analog_pd,
  input logic             digital_pd
);
  // R1
  shut_when_high_chk: assert property (@(posedge dclk)
    cs_n |-> (!dout_oe && analog_pd && digital_pd));

  // R2
  lead_bit_low_chk: assert property (@(negedge dclk) disable iff (cs_n)
    $rose(dout_oe) |-> !dout);

  // R6
  analog_off_sticky_chk: assert property (@(negedge dclk) disable iff (cs_n)
    analog_pd |=> analog_pd);

  // R4
  code_frozen_after_done_chk: assert property (@(negedge dclk) disable iff (cs_n)
    (analog_pd && $past(analog_pd)) |-> $stable(dac_code));

  // R7
  float_stays_chk: assert property (@(negedge dclk) disable iff (cs_n)
    (!ZERO_TAIL && $fell(dout_oe)) |=> !dout_oe);

  // R8
  zero_tail_low_chk: assert property (@(negedge dclk) disable iff (cs_n)
    (ZERO_TAIL && analog_pd && $past(analog_pd)) |-> (dout_oe && !dout));
endmodule

bind sar_serial_seq sar_serial_seq_chk #(.NBITS(NBITS), .ZERO_TAIL(ZERO_TAIL)) u_chk (
  .dclk(dclk), .cs_n(cs_n), .dout(dout), .dout_oe(dout_oe),
  .dac_code(dac_code), .analog_pd(analog_pd), .digital_pd(digital_pd)
);

// File: tb/tb_sar_serial_seq.sv
module tb_sar_serial_seq;
  localparam int N        = 12;
  localparam int CLK_HALF = 10;
  localparam int CLK_PER  = 2 * CLK_HALF;

  logic         dclk = 1'b0;
  logic         cs_n = 1'b1;
  logic [N-1:0] target = '0;
  logic         cmp_a, cmp_z;
  logic         dout_a, oe_a, apd_a, dpd_a;
  logic         dout_z, oe_z, apd_z, dpd_z;
  logic [N-1:0] dac_a, dac_z;
  int           checks = 0;
  int           fails  = 0;

  always #CLK_HALF dclk = ~dclk;

  assign cmp_a = (target >= dac_a);
  assign cmp_z = (target >= dac_z);

  sar_serial_seq #(.NBITS(N), .ZERO_TAIL(1'b0)) dut (
    .dclk(dclk), .cs_n(cs_n), .cmp_hi(cmp_a), .dout(dout_a), .dout_oe(oe_a),
    .dac_code(dac_a), .analog_pd(apd_a), .digital_pd(dpd_a)
  );

  sar_serial_seq #(.NBITS(N), .ZERO_TAIL(1'b1)) dut_z (
    .dclk(dclk), .cs_n(cs_n), .cmp_hi(cmp_z), .dout(dout_z), .dout_oe(oe_z),
    .dac_code(dac_z), .analog_pd(apd_z), .digital_pd(dpd_z)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Expected {oe, dout} after falling edge k of a cycle.
  function automatic logic [1:0] exp_line(input int k, input logic [N-1:0] t, input bit zt);
    if (k < 2)          return 2'b00;
    if (k == 2)         return 2'b10;
    if (k <= N + 2)     return {1'b1, t[N + 2 - k]};
    if (zt)             return 2'b10;
    if (k <= 2 * N + 1) return {1'b1, t[k - N - 2]};
    return 2'b00;
  endfunction

  // Expected trial code between edge k and k+1, k = 2..N+1.
  function automatic logic [N-1:0] exp_dac(input int k, input logic [N-1:0] t);
    int i;
    logic [N-1:0] upper;
    i = N + 1 - k;
    upper = (i == N - 1) ? '0 : ((t >> (i + 1)) << (i + 1));
    return upper | (N'(1) << i);
  endfunction

  task automatic abort_check();
    @(posedge dclk); #1;
    cs_n = 1'b1;
    #1;
    chk("R1 oe", oe_a, 1'b0);
    chk("R1 apd", apd_a, 1'b1);
    chk("R1 dpd", dpd_a, 1'b1);
    chk("R1 oe zt", oe_z, 1'b0);
  endtask

  // Lower select, run nedges falling edges, check each, then raise select.
  task automatic cycle(input logic [N-1:0] t, input int nedges);
    logic [1:0] e;
    target = t;
    @(posedge dclk); #1;
    cs_n = 1'b0;
    for (int k = 1; k <= nedges; k++) begin
      @(negedge dclk);
      @(posedge dclk); #1;
      e = exp_line(k, t, 1'b0);
      chk(k <= 2 ? "R2 oe" : (k <= N + 2 ? "R3 oe" : "R7 oe"), oe_a, e[1]);
      if (e[1]) chk(k == 2 ? "R2 lead" : (k <= N + 2 ? "R3 bit" : "R7 replay"), dout_a, e[0]);
      e = exp_line(k, t, 1'b1);
      chk("R8 oe", oe_z, e[1]);
      if (e[1]) chk("R8 bit", dout_z, e[0]);
      if (k >= 2 && k <= N + 1) chk("R4 dac", dac_a, exp_dac(k, t));
      chk("R6 apd", apd_a, (k >= N + 2));
      chk("R6 dpd", dpd_a, 1'b0);
    end
    abort_check();
  endtask

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (2) @(posedge dclk);
    #1;
    chk("R1 reset oe", oe_a, 1'b0);
    chk("R1 reset apd", apd_a, 1'b1);
    chk("R1 reset dpd", dpd_a, 1'b1);
    // R5 straight binary corners, full cycle plus long tail
    cycle(12'h000, 2 * N + 6);
    cycle(12'h7FF, 2 * N + 6);
    cycle(12'h800, 2 * N + 6);
    cycle(12'hFFF, 3 * N + 10);
    // R9 short cycle then full restart
    cycle(12'hA5C, 6);
    cycle(12'h3C9, 2 * N + 3);
    cycle(12'h5A3, 1);
    cycle(12'h5A3, N + 2);
    for (int r = 0; r < 40; r++) begin
      logic [N-1:0] t;
      int len;
      t = N'($urandom);
      len = ($urandom % 2) ? (2 * N + 4) : (1 + int'($urandom % (N + 3)));
      cycle(t, len);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PER * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule